// File: doc/BRIEF.md
# Asynchronous 16-bit PSRAM Cycle Controller

This block sits between a synchronous host and an external 16-bit pseudo-static memory with a 19-bit word address and an asynchronous interface. The host sends one word request at a time over a valid/ready port. Each request carries an address, write data, a two-bit lane mask and a write flag. The controller turns each request into one complete asynchronous read or write cycle on the memory pins. A read returns its data through a single-cycle response strobe.

Every wait inside a cycle comes from nanosecond timing parameters and a clock-period parameter. Each wait is rounded up to whole clock cycles when the design elaborates. The sequencer has five states:

- `ST_IDLE` is the only state that accepts a request. It goes to `ST_RD_ACCESS` for a read or `ST_WR_RELEASE` for a write.
- `ST_RD_ACCESS` holds the read strobes for the access time. It then goes to `ST_RECOVER`, and the data is captured on that edge.
- `ST_WR_RELEASE` holds write enable low while the memory lets go of the bus. It then goes to `ST_WR_DRIVE`.
- `ST_WR_DRIVE` drives the write data for the data-setup time. It then goes to `ST_RECOVER`, and all write strobes end on that edge.
- `ST_RECOVER` keeps every strobe inactive until the memory outputs are back in high-Z. It then returns to `ST_IDLE`.

With the default 10 ns clock, the counts are:

| Cycle part | Clock cycles |
|---|---|
| Read access | 7 |
| Bus release at write start | 3 |
| Data drive | 5 |
| Recovery | 3 |

Top module: `psram_ctrl`

## Requirements
- R1: While `rst_n` is low, the memory pins are inactive: `mem_ce_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_ub_n`=1 and `mem_lb_n`=1. `mem_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: A read is accepted on an edge where `req_valid` and `req_ready` are both high. From that edge, for 7 cycles (the read-access count), the pins hold `mem_ce_n`=0, `mem_ce2`=1, `mem_oe_n`=0 and `mem_we_n`=1, with `mem_addr` equal to the request address. On the edge that ends the access, `mem_dq_i` is captured and `rsp_valid` pulses high for exactly one cycle with `rsp_rdata`.
- R3: Bit 0 of `req_be` selects the lane on bits 7:0 and drives `mem_lb_n` low. Bit 1 selects bits 15:8 and drives `mem_ub_n` low. In a read, a lane whose mask bit is 0 returns zero in `rsp_rdata`. In a write, that lane is left unchanged in memory.
- R4: At write acceptance, `mem_we_n`, `mem_ce_n`, `mem_ce2` and the selected lane enables become active on the same edge. They all return inactive together 8 cycles later. `mem_oe_n` stays 1 for the whole write.
- R5: The controller leaves `mem_dq_oe` at 0 for the first 3 cycles of a write. It then drives `mem_dq_o` with the write data for 5 cycles. It drops `mem_dq_oe` on the edge where `mem_we_n` rises. It never drives while `mem_oe_n` is 0.
- R6: Every cycle is followed by 3 cycles with all strobes inactive and `req_ready` at 0. `req_ready` is 1 only when no cycle or recovery is in progress.
- R7: Address, data and mask are captured at acceptance. Changes on the request inputs while a cycle is in progress do not change `mem_addr`, `mem_dq_o` or the lane enables.
- R8: A request with mask 00 still runs a full cycle, but both lane enables stay high. Such a write changes no memory word, and such a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit0 = bits 7:0, bit1 = bits 15:8 |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_ub_n | output | 1 | Active-low enable, bits 15:8 |
| mem_lb_n | output | 1 | Active-low enable, bits 7:0 |
| mem_dq_o | output | 16 | Data toward the pads |
| mem_dq_oe | output | 1 | Pad driver enable for `mem_dq_o` |
| mem_dq_i | input | 16 | Data from the pads |

## Verification
Two pairs of functions fall on the same edge and are judged by comparing the pins cycle by cycle.

The first pair is the read capture and the end of the read. The edge that captures `mem_dq_i` also raises `mem_oe_n` and the chip enables. The bench's memory model presents valid data only once the access count has elapsed, so a capture one cycle early would return the model's filler pattern.

The second pair is the rising edge of write enable and the release of the data pads. The model commits a write only if the data was driven for the full setup window before the strobes ended.

Request inputs are also changed while a cycle runs, to show that these changes do not reach the pins.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_WR_RELEASE,
        ST_WR_DRIVE,
        ST_RECOVER
    } seq_state_e;

    // Round a duration up to a whole number of clock periods.
    function automatic int ps_to_cycles(input int t_ps, input int clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_cycle_timer.sv
module psram_cycle_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/psram_seq_fsm.sv
module psram_seq_fsm
    import psram_pkg::*;
#(
    parameter int CNT_W   = 3,
    parameter int LANES   = 2,
    parameter int RD_CYC  = 7,
    parameter int WZ_CYC  = 3,
    parameter int WD_CYC  = 5,
    parameter int REC_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LANES-1:0] req_be,
    input  logic [LANES-1:0] held_be,
    input  logic             expired,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             req_ready,
    output logic             accept,
    output logic             sample,
    output logic             mem_ce_n,
    output logic             mem_ce2,
    output logic             mem_we_n,
    output logic             mem_oe_n,
    output logic [LANES-1:0] lane_n,
    output logic             dq_oe
);
    localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WZ_LOAD  = CNT_W'(WZ_CYC - 1);
    localparam logic [CNT_W-1:0] WD_LOAD  = CNT_W'(WD_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(REC_CYC - 1);

    seq_state_e       state_q, state_d;
    logic [LANES-1:0] be_sel;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign sample    = (state_q == ST_RD_ACCESS) && expired;
    assign be_sel    = accept ? req_be : held_be;

    // Next state and timer reload
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    timer_load = 1'b1;
                    if (req_write) begin
                        state_d   = ST_WR_RELEASE;
                        timer_val = WZ_LOAD;
                    end else begin
                        state_d   = ST_RD_ACCESS;
                        timer_val = RD_LOAD;
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (expired) begin
                    state_d    = ST_RECOVER;
                    timer_load = 1'b1;
                    timer_val  = REC_LOAD;
                end
            end
            ST_WR_RELEASE: begin
                if (expired) begin
                    state_d    = ST_WR_DRIVE;
                    timer_load = 1'b1;
                    timer_val  = WD_LOAD;
                end
            end
            ST_WR_DRIVE: begin
                if (expired) begin
                    state_d    = ST_RECOVER;
                    timer_load = 1'b1;
                    timer_val  = REC_LOAD;
                end
            end
            ST_RECOVER: begin
                if (expired) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered strobes, decoded from the state being entered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n <= 1'b1;
            mem_ce2  <= 1'b0;
            mem_we_n <= 1'b1;
            mem_oe_n <= 1'b1;
            lane_n   <= '1;
            dq_oe    <= 1'b0;
        end else begin
            unique case (state_d)
                ST_RD_ACCESS: begin
                    mem_ce_n <= 1'b0;
                    mem_ce2  <= 1'b1;
                    mem_we_n <= 1'b1;
                    mem_oe_n <= 1'b0;
                    lane_n   <= ~be_sel;
                    dq_oe    <= 1'b0;
                end
                ST_WR_RELEASE: begin
                    mem_ce_n <= 1'b0;
                    mem_ce2  <= 1'b1;
                    mem_we_n <= 1'b0;
                    mem_oe_n <= 1'b1;
                    lane_n   <= ~be_sel;
                    dq_oe    <= 1'b0;
                end
                ST_WR_DRIVE: begin
                    mem_ce_n <= 1'b0;
                    mem_ce2  <= 1'b1;
                    mem_we_n <= 1'b0;
                    mem_oe_n <= 1'b1;
                    lane_n   <= ~be_sel;
                    dq_oe    <= 1'b1;
                end
                default: begin
                    mem_ce_n <= 1'b1;
                    mem_ce2  <= 1'b0;
                    mem_we_n <= 1'b1;
                    mem_oe_n <= 1'b1;
                    lane_n   <= '1;
                    dq_oe    <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/psram_datapath.sv
module psram_datapath #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              sample,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [LANES-1:0]  held_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] lane_mask;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{held_be[g]}};
    end

    // Request capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dq_o <= '0;
            held_be  <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_dq_o <= req_wdata;
            held_be  <= req_be;
        end
    end

    // Read capture with lane masking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= sample;
            if (sample) begin
                rsp_rdata <= mem_dq_i & lane_mask;
            end
        end
    end
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_PS = 10000,
    parameter int T_CYCLE_PS    = 70000,
    parameter int T_ADDR_ACC_PS = 70000,
    parameter int T_OE_ACC_PS   = 35000,
    parameter int T_LANE_ACC_PS = 70000,
    parameter int T_WE_MIN_PS   = 45000,
    parameter int T_SEL_WR_PS   = 60000,
    parameter int T_DSETUP_PS   = 45000,
    parameter int T_WE_HIZ_PS   = 25000,
    parameter int T_OUT_HIZ_PS  = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int LANES = 2;

    // Cycle counts, each rounded up from the nanosecond limits
    localparam int RD_CYC = imax(1, imax(
        imax(ps_to_cycles(T_CYCLE_PS, CLK_PERIOD_PS), ps_to_cycles(T_ADDR_ACC_PS, CLK_PERIOD_PS)),
        imax(ps_to_cycles(T_OE_ACC_PS, CLK_PERIOD_PS), ps_to_cycles(T_LANE_ACC_PS, CLK_PERIOD_PS))));

    localparam int WZ_CYC = imax(1, ps_to_cycles(T_WE_HIZ_PS, CLK_PERIOD_PS));

    localparam int WD_CYC = imax(1, imax(
        imax(ps_to_cycles(T_DSETUP_PS, CLK_PERIOD_PS), ps_to_cycles(T_WE_MIN_PS, CLK_PERIOD_PS) - WZ_CYC),
        imax(ps_to_cycles(T_SEL_WR_PS, CLK_PERIOD_PS) - WZ_CYC, ps_to_cycles(T_CYCLE_PS, CLK_PERIOD_PS) - WZ_CYC)));

    localparam int REC_CYC = imax(1, ps_to_cycles(T_OUT_HIZ_PS, CLK_PERIOD_PS));
    localparam int MAX_CYC = imax(imax(RD_CYC, WZ_CYC), imax(WD_CYC, REC_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             expired;
    logic             accept;
    logic             sample;
    logic [LANES-1:0] held_be;
    logic [LANES-1:0] lane_n;

    psram_cycle_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (expired)
    );

    psram_seq_fsm #(
        .CNT_W   (CNT_W),
        .LANES   (LANES),
        .RD_CYC  (RD_CYC),
        .WZ_CYC  (WZ_CYC),
        .WD_CYC  (WD_CYC),
        .REC_CYC (REC_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_be     (req_be),
        .held_be    (held_be),
        .expired    (expired),
        .timer_load (timer_load),
        .timer_val  (timer_val),
        .req_ready  (req_ready),
        .accept     (accept),
        .sample     (sample),
        .mem_ce_n   (mem_ce_n),
        .mem_ce2    (mem_ce2),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .lane_n     (lane_n),
        .dq_oe      (mem_dq_oe)
    );

    psram_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .sample    (sample),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .mem_dq_i  (mem_dq_i),
        .held_be   (held_be),
        .mem_addr  (mem_addr),
        .mem_dq_o  (mem_dq_o),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign mem_lb_n = lane_n[0];
    assign mem_ub_n = lane_n[1];
endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
    parameter int ADDR_W = 19,
    parameter int WZ_CYC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_ce2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_ub_n,
    input logic              mem_lb_n,
    input logic              mem_dq_oe
);
    localparam int CW = $clog2(WZ_CYC + 2);

    // Cycles elapsed since write enable fell, saturating
    logic [CW-1:0] we_low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || mem_we_n) begin
            we_low_cnt <= '0;
        end else if (we_low_cnt != CW'(WZ_CYC)) begin
            we_low_cnt <= we_low_cnt + 1'b1;
        end
    end

    assert_oe_high_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    assert_strobes_end_together_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_ce_n && !mem_ce2 && mem_ub_n && mem_lb_n));

    assert_release_on_we_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_dq_oe);

    assert_drive_only_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n));

    assert_drive_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (we_low_cnt >= CW'(WZ_CYC)));

    assert_ready_only_when_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_single_response_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_addr_held_in_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind psram_ctrl psram_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .WZ_CYC (WZ_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_ce2   (mem_ce2),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_ub_n  (mem_ub_n),
    .mem_lb_n  (mem_lb_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_psram_ctrl.sv
`timescale 1ns/1ps
module sim_psram_ctrl;
    // Expected counts for a 10 ns clock, from the requirements
    localparam int RD  = 7;
    localparam int WZ  = 3;
    localparam int WD  = 5;
    localparam int REC = 3;

    typedef struct packed {
        logic        ce_n, ce2, we_n, oe_n, ub_n, lb_n, dq_oe, ready, rsp;
        logic        chk_addr, chk_dq;
        logic [18:0] addr;
        logic [15:0] dq;
        logic [15:0] rdata;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n;
    logic [15:0] mem_dq_o;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_i = 16'h3CC3;

    int    checks = 0;
    int    errors = 0;
    bit    reported = 1'b0;
    exp_t  expq[$];
    string tagq[$];
    string idle_tag = "R1";

    logic [15:0] ref_mem [int];
    logic [15:0] pin_mem [int];
    logic [31:0] rng = 32'h1ACE5EED;

    // Pin-level memory model state
    int          acc_cnt = 0;
    int          we_low = 0;
    int          drv_cnt = 0;
    int          prev_drv = 0;
    logic [18:0] last_a = '0;
    logic        prev_wr = 1'b0;
    logic        prev_lb_n = 1'b1, prev_ub_n = 1'b1;
    logic [18:0] prev_a = '0;
    logic [15:0] prev_dq = '0;

    always #5 clk = ~clk;

    psram_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .req_write (req_write),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_ce2   (mem_ce2),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_ub_n  (mem_ub_n),
        .mem_lb_n  (mem_lb_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .mem_dq_i  (mem_dq_i)
    );

    function automatic logic [15:0] ref_rd(input logic [18:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
    endfunction

    function automatic logic [15:0] pin_rd(input logic [18:0] a);
        return pin_mem.exists(int'(a)) ? pin_mem[int'(a)] : 16'h0000;
    endfunction

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic exp_t idle_exp();
        exp_t e;
        e = '0;
        e.ce_n = 1'b1; e.we_n = 1'b1; e.oe_n = 1'b1;
        e.ub_n = 1'b1; e.lb_n = 1'b1; e.ready = 1'b1;
        return e;
    endfunction

    task automatic step_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
    endtask

    task automatic fail(input string tag, input string what);
        errors++;
        $display("FAIL %s %s", tag, what);
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    task automatic compare();
        exp_t  e;
        string t;
        bit    bad;
        if (expq.size() > 0) begin
            e = expq.pop_front();
            t = tagq.pop_front();
        end else begin
            e = idle_exp();
            t = idle_tag;
        end
        checks++;
        bad = ({mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready, rsp_valid}
               != {e.ce_n, e.ce2, e.we_n, e.oe_n, e.ub_n, e.lb_n, e.dq_oe, e.ready, e.rsp});
        if (e.chk_addr && mem_addr != e.addr) bad = 1'b1;
        if (e.chk_dq && mem_dq_o != e.dq) bad = 1'b1;
        if (e.rsp && rsp_rdata != e.rdata) bad = 1'b1;
        if (bad) begin
            fail(t, $sformatf("pins actual=%b addr=%h dq=%h rd=%h expected=%b addr=%h dq=%h rd=%h",
                {mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready, rsp_valid},
                mem_addr, mem_dq_o, rsp_rdata,
                {e.ce_n, e.ce2, e.we_n, e.oe_n, e.ub_n, e.lb_n, e.dq_oe, e.ready, e.rsp},
                e.addr, e.dq, e.rdata));
        end
    endtask

    // Memory model: access delay, bus-release window, write commit
    task automatic model_update();
        logic        rd_on, wr_on;
        logic [15:0] cur;
        rd_on = !mem_ce_n && mem_ce2 && mem_we_n && !mem_oe_n && (!mem_lb_n || !mem_ub_n);
        wr_on = !mem_we_n && !mem_ce_n && mem_ce2 && (!mem_lb_n || !mem_ub_n);
        if (rd_on) acc_cnt = (acc_cnt > 0 && mem_addr == last_a) ? acc_cnt + 1 : 1;
        else       acc_cnt = 0;
        last_a = mem_addr;
        we_low = mem_we_n ? 0 : we_low + 1;
        if (mem_dq_oe) begin
            checks++;
            if (mem_we_n || !mem_oe_n || we_low < WZ + 1)
                fail("R5", $sformatf("drive window actual we_low=%0d we_n=%b oe_n=%b expected we_low>=%0d we_n=0 oe_n=1",
                    we_low, mem_we_n, mem_oe_n, WZ + 1));
        end
        drv_cnt = (wr_on && mem_dq_oe) ? drv_cnt + 1 : 0;
        if (prev_wr && !wr_on) begin
            checks++;
            if (prev_drv < WD) begin
                fail("R5", $sformatf("data setup actual=%0d expected>=%0d", prev_drv, WD));
            end else begin
                cur = pin_rd(prev_a);
                if (!prev_lb_n) cur[7:0]  = prev_dq[7:0];
                if (!prev_ub_n) cur[15:8] = prev_dq[15:8];
                pin_mem[int'(prev_a)] = cur;
            end
        end
        prev_wr   = wr_on;
        prev_drv  = drv_cnt;
        prev_lb_n = mem_lb_n;
        prev_ub_n = mem_ub_n;
        prev_a    = mem_addr;
        prev_dq   = mem_dq_o;
        cur = pin_rd(mem_addr);
        mem_dq_i[7:0]  = (rd_on && acc_cnt >= RD && !mem_lb_n) ? cur[7:0]  : 8'hC3;
        mem_dq_i[15:8] = (rd_on && acc_cnt >= RD && !mem_ub_n) ? cur[15:8] : 8'h3C;
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
        model_update();
    endtask

    task automatic issue(input bit wr, input logic [18:0] a, input logic [15:0] d, input logic [1:0] be);
        exp_t  e;
        string tg;
        while (expq.size() != 0) tick();
        tick();
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        e = '0;
        e.ce2 = 1'b1; e.ub_n = ~be[1]; e.lb_n = ~be[0];
        e.chk_addr = 1'b1; e.addr = a;
        if (!wr) begin
            e.we_n = 1'b1;
            tg = (be == 2'b00) ? "R8" : (be == 2'b11) ? "R2" : "R3";
            for (int k = 0; k < RD; k++) begin expq.push_back(e); tagq.push_back(tg); end
            e = idle_exp(); e.ready = 1'b0; e.rsp = 1'b1;
            e.rdata = ref_rd(a) & lane_mask(be);
            expq.push_back(e); tagq.push_back(tg);
            e.rsp = 1'b0;
            for (int k = 1; k < REC; k++) begin expq.push_back(e); tagq.push_back("R6"); end
        end else begin
            e.oe_n = 1'b1;
            tg = (be == 2'b00) ? "R8" : "R4";
            for (int k = 0; k < WZ; k++) begin expq.push_back(e); tagq.push_back(tg); end
            e.dq_oe = 1'b1; e.chk_dq = 1'b1; e.dq = d;
            for (int k = 0; k < WD; k++) begin expq.push_back(e); tagq.push_back("R5"); end
            e = idle_exp(); e.ready = 1'b0;
            for (int k = 0; k < REC; k++) begin expq.push_back(e); tagq.push_back("R6"); end
            ref_mem[int'(a)] = (ref_rd(a) & ~lane_mask(be)) | (d & lane_mask(be));
        end
        tick();
        // R7: scramble request inputs while the cycle runs
        step_rng();
        req_valid = 1'b0; req_write = rng[0]; req_addr = rng[18:0];
        req_wdata = rng[31:16]; req_be = rng[9:8];
    endtask

    initial begin
        // R1: reset state
        tick();
        tick();
        rst_n = 1'b1;
        idle_tag = "R6";
        tick();
        // R4 R5 R2: full-word write and read back
        issue(1'b1, 19'h00010, 16'h1234, 2'b11);
        issue(1'b0, 19'h00010, 16'h0000, 2'b11);
        // R3: lane writes and lane reads
        issue(1'b1, 19'h00010, 16'hFFAB, 2'b01);
        issue(1'b0, 19'h00010, 16'h0000, 2'b11);
        issue(1'b1, 19'h00010, 16'hCD77, 2'b10);
        issue(1'b0, 19'h00010, 16'h0000, 2'b10);
        issue(1'b0, 19'h00010, 16'h0000, 2'b01);
        // R8: empty mask
        issue(1'b1, 19'h00010, 16'h9999, 2'b00);
        issue(1'b0, 19'h00010, 16'h0000, 2'b11);
        issue(1'b0, 19'h00010, 16'h0000, 2'b00);
        // Address extremes
        issue(1'b1, 19'h7FFFF, 16'hA55A, 2'b11);
        issue(1'b1, 19'h00000, 16'h5AA5, 2'b11);
        issue(1'b0, 19'h7FFFF, 16'h0000, 2'b11);
        issue(1'b0, 19'h00000, 16'h0000, 2'b11);
        // Mixed traffic over a few addresses
        for (int i = 0; i < 24; i++) begin
            step_rng();
            issue(rng[0], 19'h2A000 + 19'(rng[4:3]), rng[31:16], rng[6:5]);
        end
        for (int i = 0; i < 4; i++) issue(1'b0, 19'h2A000 + 19'(i), 16'h0000, 2'b11);
        while (expq.size() != 0) tick();
        tick();
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fail("watchdog", "actual=timeout expected=completion");
        report();
        $finish;
    end
endmodule